// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit decides conditional branches and jumps for a 32-bit load/store processor whose pipeline has one branch delay slot. Each cycle the decode stage may present one instruction: its address, the two register operand values it reads, a branch-kind code, a 16-bit word offset and a 26-bit jump index. One clock later the unit reports whether a redirect was decided, the address of the instruction that executes next, and whether the return-address register (register 31) is to be written, with the value to write.

The instruction after a branch or jump always executes. The unit therefore does not steer fetch at the branch itself: it remembers a decided redirect and applies it when the delay-slot instruction is presented, so the slot's successor is the branch target. Equality forms compare both operands; the zero-compare forms test the first operand as a two's-complement number. Two zero-compare forms and one jump form also link, writing the address just past the delay slot.

Top module: `brx_resolver`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, out_taken and out_link_we are 0 and out_next_pc and out_link_val are 0.
- R2: Kind 1 (equal) is taken when in_rs equals in_rt over all 32 bits; kind 2 (not equal) is taken when they differ.
- R3: Kinds 3 (at most zero), 4 (above zero), 5 (below zero) and 6 (zero or above) test in_rs as a signed 32-bit value; 0x80000000 counts as negative and 0 as neither above nor below zero. in_rt is not used.
- R4: A taken conditional branch targets in_pc + 4 + (sign-extended in_off times 4), including negative offsets.
- R5: Kinds 9 (jump) and 10 (jump and link) are always taken and target {bits 31:28 of in_pc+4, in_jidx, 2'b00}.
- R6: Kinds 7 (below zero and link), 8 (zero or above and link) and 10 raise out_link_we with out_link_val = in_pc + 8 whether or not taken; no other kind raises out_link_we, and out_link_val holds its last written value otherwise.
- R7: For an instruction that is not in a delay slot, out_next_pc = in_pc + 4, also for a taken branch or jump.
- R8: The next valid instruction after a taken branch is its delay slot: out_next_pc equals the branch target, and any branch kind it carries is ignored (out_taken and out_link_we stay 0, and no new redirect is recorded).
- R9: Results appear on the clock edge after the instruction is presented. A cycle with in_valid low gives out_valid, out_taken and out_link_we low, leaves out_next_pc unchanged, and keeps a pending redirect for the next valid instruction.
- R10: Kind 0 and the unused codes 11 to 15 act as non-branch instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_pc | input | 32 | Address of the presented instruction |
| in_rs | input | 32 | First register operand |
| in_rt | input | 32 | Second register operand |
| in_kind | input | 4 | Branch-kind code (see R2, R3, R5, R6, R10) |
| in_off | input | 16 | Signed word offset for conditional branches |
| in_jidx | input | 26 | Word index for jumps |
| out_valid | output | 1 | Results below belong to an instruction |
| out_taken | output | 1 | The instruction decided a redirect |
| out_next_pc | output | 32 | Address of the instruction executing next |
| out_link_we | output | 1 | Write register 31 |
| out_link_val | output | 32 | Return address for register 31 |

## Verification
Every result of an instruction presented before a rising edge is due right after that edge, so the bench drives at the falling edge and compares the previous instruction's expected outputs at the next falling edge, before driving anew. A redirect's target is due one valid instruction later, at the delay slot's result, however many idle cycles lie between; the reference model carries the pending target across idle cycles and checks it only then.

// File: rtl/brx_pkg.sv
package brx_pkg;
    localparam int XLEN  = 32;
    localparam int OFFW  = 16;
    localparam int JIDXW = 26;
    localparam int KINDW = 4;

    typedef enum logic [KINDW-1:0] {
        BK_NONE  = 4'd0,
        BK_EQ    = 4'd1,
        BK_NE    = 4'd2,
        BK_LEZ   = 4'd3,
        BK_GTZ   = 4'd4,
        BK_LTZ   = 4'd5,
        BK_GEZ   = 4'd6,
        BK_LTZL  = 4'd7,
        BK_GEZL  = 4'd8,
        BK_JMP   = 4'd9,
        BK_JMPL  = 4'd10
    } brx_kind_e;

    typedef struct packed {
        logic            vld;
        logic            tkn;
        logic            lwe;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] lval;
        logic            pend;
        logic [XLEN-1:0] ptgt;
    } brx_state_t;
endpackage

// File: rtl/brx_cond.sv
module brx_cond
    import brx_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [KINDW-1:0] kind,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    output logic             take,
    output logic             is_jump,
    output logic             is_link
);
    logic neg;
    logic zero;

    always_comb begin
        neg     = opa[W-1];
        zero    = (opa == '0);
        take    = 1'b0;
        is_jump = 1'b0;
        is_link = 1'b0;
        case (kind)
            BK_EQ:   take = (opa == opb);
            BK_NE:   take = (opa != opb);
            BK_LEZ:  take = neg | zero;
            BK_GTZ:  take = ~neg & ~zero;
            BK_LTZ:  take = neg;
            BK_GEZ:  take = ~neg;
            BK_LTZL: begin take = neg;  is_link = 1'b1; end
            BK_GEZL: begin take = ~neg; is_link = 1'b1; end
            BK_JMP:  begin take = 1'b1; is_jump = 1'b1; end
            BK_JMPL: begin take = 1'b1; is_jump = 1'b1; is_link = 1'b1; end
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/brx_target.sv
module brx_target
    import brx_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int OW = OFFW,
    parameter int JW = JIDXW
) (
    input  logic [W-1:0]  pc,
    input  logic [OW-1:0] off,
    input  logic [JW-1:0] jidx,
    input  logic          is_jump,
    output logic [W-1:0]  seq,
    output logic [W-1:0]  tgt,
    output logic [W-1:0]  link
);
    localparam int EXTW = W - OW - 2;
    localparam int HIW  = W - JW - 2;

    logic [W-1:0] off_ext;
    logic [W-1:0] br_tgt;
    logic [W-1:0] j_tgt;

    always_comb begin
        seq     = pc + W'(4);
        link    = pc + W'(8);
        off_ext = {{EXTW{off[OW-1]}}, off, 2'b00};
        br_tgt  = seq + off_ext;
        j_tgt   = {seq[W-1 -: HIW], jidx, 2'b00};
        tgt     = is_jump ? j_tgt : br_tgt;
    end
endmodule

// File: rtl/brx_resolver.sv
module brx_resolver
    import brx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [XLEN-1:0]   in_rs,
    input  logic [XLEN-1:0]   in_rt,
    input  logic [KINDW-1:0]  in_kind,
    input  logic [OFFW-1:0]   in_off,
    input  logic [JIDXW-1:0]  in_jidx,
    output logic              out_valid,
    output logic              out_taken,
    output logic [XLEN-1:0]   out_next_pc,
    output logic              out_link_we,
    output logic [XLEN-1:0]   out_link_val
);
    logic            take;
    logic            is_jump;
    logic            is_link;
    logic [XLEN-1:0] seq;
    logic [XLEN-1:0] tgt;
    logic [XLEN-1:0] link;

    brx_state_t st_d;
    brx_state_t st_q;

    brx_cond #(.W(XLEN)) u_cond (
        .kind    (in_kind),
        .opa     (in_rs),
        .opb     (in_rt),
        .take    (take),
        .is_jump (is_jump),
        .is_link (is_link)
    );

    brx_target #(.W(XLEN), .OW(OFFW), .JW(JIDXW)) u_tgt (
        .pc      (in_pc),
        .off     (in_off),
        .jidx    (in_jidx),
        .is_jump (is_jump),
        .seq     (seq),
        .tgt     (tgt),
        .link    (link)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.tkn = 1'b0;
        st_d.lwe = 1'b0;
        if (in_valid) begin
            if (st_q.pend) begin
                st_d.npc  = st_q.ptgt;
                st_d.pend = 1'b0;
            end else begin
                st_d.npc  = seq;
                st_d.tkn  = take;
                st_d.pend = take;
                st_d.ptgt = tgt;
                st_d.lwe  = is_link;
                if (is_link) begin
                    st_d.lval = link;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.vld;
    assign out_taken    = st_q.tkn;
    assign out_next_pc  = st_q.npc;
    assign out_link_we  = st_q.lwe;
    assign out_link_val = st_q.lval;

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_taken && !out_link_we));

    // R9
    idle_hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_next_pc));

    // R7
    taken_slot_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !st_q.pend) |=> (out_next_pc == $past(in_pc) + XLEN'(4)));

    // R6
    link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !st_q.pend) |=> (!out_link_we || out_link_val == $past(in_pc) + XLEN'(8)));

    // R8
    slot_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && st_q.pend) |=> (!out_taken && !out_link_we && !st_q.pend));

    // R8
    slot_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_taken |-> st_q.pend);

    // R5
    jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !st_q.pend && (in_kind == BK_JMP || in_kind == BK_JMPL)) |=> out_taken);
endmodule

// File: tb/tb_brx_resolver.sv
module tb_brx_resolver;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_rs = '0;
    logic [31:0] in_rt = '0;
    logic [3:0]  in_kind = '0;
    logic [15:0] in_off = '0;
    logic [25:0] in_jidx = '0;
    logic        out_valid;
    logic        out_taken;
    logic [31:0] out_next_pc;
    logic        out_link_we;
    logic [31:0] out_link_val;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit          m_pend = 0;
    logic [31:0] m_ptgt = '0;
    bit          e_vld = 0, e_tkn = 0, e_lwe = 0;
    logic [31:0] e_npc = '0, e_lval = '0;
    string       e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    brx_resolver dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pc(in_pc),
        .in_rs(in_rs), .in_rt(in_rt), .in_kind(in_kind), .in_off(in_off),
        .in_jidx(in_jidx), .out_valid(out_valid), .out_taken(out_taken),
        .out_next_pc(out_next_pc), .out_link_we(out_link_we),
        .out_link_val(out_link_val)
    );

    function automatic bit ref_cond(input int kind, input logic [31:0] a, input logic [31:0] b);
        int sa;
        sa = $signed(a);
        case (kind)
            1:  return a == b;
            2:  return a != b;
            3:  return sa <= 0;
            4:  return sa > 0;
            5, 7: return sa < 0;
            6, 8: return sa >= 0;
            9, 10: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== e_vld || out_taken !== e_tkn || out_link_we !== e_lwe ||
            out_next_pc !== e_npc || out_link_val !== e_lval) begin
            errors++;
            $display("FAIL %s: got vld=%0b tkn=%0b lwe=%0b npc=%h lval=%h, expected vld=%0b tkn=%0b lwe=%0b npc=%h lval=%h",
                     e_tag, out_valid, out_taken, out_link_we, out_next_pc, out_link_val,
                     e_vld, e_tkn, e_lwe, e_npc, e_lval);
        end
    endtask

    task automatic step(input bit vld, input logic [31:0] pc, input logic [31:0] rs,
                        input logic [31:0] rt, input int kind, input logic [15:0] off,
                        input logic [25:0] jidx, input string tag);
        int          k;
        bit          t;
        logic [31:0] tg;
        @(negedge clk);
        compare();
        in_valid = vld; in_pc = pc; in_rs = rs; in_rt = rt;
        in_kind = 4'(kind); in_off = off; in_jidx = jidx;
        e_tag = tag;
        k = kind;
        e_tkn = 0; e_lwe = 0; e_vld = vld;
        if (vld) begin
            if (m_pend) begin
                e_npc  = m_ptgt;
                m_pend = 0;
            end else begin
                e_npc = pc + 32'd4;
                t = ref_cond(k, rs, rt);
                if (k == 9 || k == 10)
                    tg = {e_npc[31:28], jidx, 2'b00};
                else
                    tg = pc + 32'd4 + 32'($signed(off) * 4);
                e_tkn  = t;
                m_pend = t;
                m_ptgt = tg;
                if (k == 7 || k == 8 || k == 10) begin
                    e_lwe  = 1;
                    e_lval = pc + 32'd8;
                end
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R2: equality forms
        step(1, 32'h100, 32'h1234, 32'h1234, 1, 16'h0010, 0, "R2");
        step(1, 32'h104, 0, 0, 0, 0, 0, "R8");
        step(1, 32'h200, 32'h8000_0001, 32'h0000_0001, 1, 16'h0004, 0, "R2");
        step(1, 32'h204, 32'h5, 32'h5, 2, 16'h0004, 0, "R2");
        step(1, 32'h208, 32'h5, 32'h6, 2, 16'hFFFE, 0, "R4");
        step(1, 32'h20C, 0, 0, 0, 0, 0, "R8");
        // R3: zero compares
        step(1, 32'h300, 32'h0, 32'h9, 3, 16'h0001, 0, "R3");
        step(1, 32'h304, 0, 0, 0, 0, 0, "R8");
        step(1, 32'h400, 32'h0, 32'h0, 4, 16'h0001, 0, "R3");
        step(1, 32'h404, 32'h1, 32'h0, 4, 16'h0003, 0, "R3");
        step(1, 32'h408, 0, 0, 0, 0, 0, "R8");
        step(1, 32'h500, 32'h8000_0000, 0, 4, 16'h0003, 0, "R3");
        step(1, 32'h504, 32'h8000_0000, 0, 5, 16'h8000, 0, "R4");
        step(1, 32'h508, 0, 0, 0, 0, 0, "R8");
        step(1, 32'h600, 32'h0, 0, 5, 16'h0002, 0, "R3");
        step(1, 32'h604, 32'h0, 0, 6, 16'h0002, 0, "R3");
        // R8: branch kind in the slot is ignored; R9 idle keeps pending
        step(0, 32'h0, 0, 0, 1, 0, 0, "R9");
        step(0, 32'h0, 0, 0, 0, 0, 0, "R9");
        step(1, 32'h608, 32'h7, 32'h7, 10, 16'h0005, 26'h3, "R8");
        // R6: link forms
        step(1, 32'h700, 32'h1, 0, 7, 16'h0010, 0, "R6");
        step(1, 32'h704, 32'hFFFF_FFFF, 0, 8, 16'h0010, 0, "R6");
        step(1, 32'h708, 32'h1, 0, 8, 16'h0020, 0, "R6");
        step(1, 32'h70C, 0, 0, 0, 0, 0, "R8");
        step(1, 32'h800, 32'hFFFF_FFFF, 0, 7, 16'hFFF0, 0, "R6");
        step(1, 32'h804, 0, 0, 0, 0, 0, "R8");
        // R5: jumps, region from pc+4
        step(1, 32'hAFFF_FFFC, 0, 0, 9, 0, 26'h2AA_AAAA, "R5");
        step(1, 32'hB000_0000, 0, 0, 0, 0, 0, "R5");
        step(1, 32'h3000_0010, 0, 0, 10, 0, 26'h000_0123, "R5");
        step(1, 32'h3000_0014, 0, 0, 0, 0, 0, "R5");
        // R10: unused codes act as non-branch
        for (int c = 11; c < 16; c++)
            step(1, 32'h900 + 32'(c * 4), 32'h0, 32'h0, c, 16'h0040, 26'h1, "R10");
        step(1, 32'h9F0, 32'h0, 32'h0, 0, 16'h0040, 0, "R10");
        // R7: mixed traffic
        for (int i = 0; i < 400; i++)
            step(($urandom % 5) != 0, $urandom & 32'hFFFF_FFFC,
                 (($urandom % 3) == 0) ? 32'h0 : $urandom, $urandom % 4,
                 $urandom % 16, 16'($urandom), 26'($urandom), "R7");
        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule